// File: doc/BRIEF.md
# Vector Indexed Register Move Sequencer

This block owns a small general-purpose register file and walks an indexed move across it when it receives a start strobe. In scalar mode it makes a single move. The destination register receives the register whose number is held in an index register. In vector mode it steps through elements 0 to VL-1. For each element it reads an index word from the index base plus the element number. It limits that word to VL and copies from the destination base plus the limited index into the destination base plus the element number. Because of this limit, a vector run can only read registers RT through RT+VL. That footprint is known as soon as the run starts.

Elements are handled in strict ascending order, one per clock. Each element reads and then writes in the same cycle, so a later element sees any value an earlier element has already written. A load port fills registers while the sequencer is idle. A debug read port lets the surrounding logic or a bench observe any register. The write activity of the sequencer is visible on the port list.

Top module: `ixmv_sequencer`

## Requirements
- R1: Scalar mode (`vec_mode`=0) performs one move. Register `dst_base` receives register number (value of register `idx_base`) modulo 32, and only the low 5 bits of that value select the register.
- R2: Vector mode (`vec_mode`=1) runs elements i = 0..VL-1. Element i writes register (`dst_base`+i) mod 32 with register (`dst_base`+c) mod 32, where c = min(value of register (`idx_base`+i) mod 32, VL).
- R3: The index word is compared with VL as an unsigned 64-bit number, so any value at or above VL, including values with bit 63 set, yields c = VL.
- R4: Elements run in ascending order, one per cycle. An element whose source was written by an earlier element of the same run reads the new value.
- R5: `busy` is high from the cycle after an accepted start for exactly VL cycles (1 cycle in scalar mode). `done` is high for exactly one cycle, the cycle after the final write, with `busy` low.
- R6: A vector start with VL = 0 makes no write, never raises `busy`, and raises `done` in the cycle after the start.
- R7: `start` is ignored while `busy` is high. The running operation continues with its original operands.
- R8: When `busy` is low, `ld_en` writes `ld_data` into register `ld_addr` at the clock edge. When `busy` is high, `ld_en` is ignored.
- R9: `dbg_data` combinationally returns the content of register `dbg_addr`.
- R10: While `busy` is high, `wr_en` is 1 and `wr_addr`/`wr_data` give the register and value written at the next edge.
- R11: After reset, `busy`, `done` and `wr_en` are 0 and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled when idle |
| vec_mode | input | 1 | 1 = vector run, 0 = single scalar move |
| dst_base | input | 5 | Destination base register number |
| idx_base | input | 5 | Index base register number |
| vlen | input | 6 | Vector length |
| ld_en | input | 1 | Idle-time register load enable |
| ld_addr | input | 5 | Load register number |
| ld_data | input | 64 | Load value |
| dbg_addr | input | 5 | Debug read register number |
| dbg_data | output | 64 | Debug read value |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Sequencer write this cycle |
| wr_addr | output | 5 | Sequencer write register |
| wr_data | output | 64 | Sequencer write value |

## Verification
A sequencer element write and an external load can fall in the same cycle, and so can a new start strobe and a running element. The bench drives `ld_en` to a register outside the run's destination range, and raises `start` with different operands, during the first element of vector runs. It then judges the outcome by reading every register through the debug port against a reference model that dropped both. The per-element `wr_addr`/`wr_data` checks and the busy length show whether the run kept its original operands.

// File: rtl/ixmv_pkg.sv
package ixmv_pkg;
   typedef enum logic {
      MV_SCALAR = 1'b0,
      MV_VECTOR = 1'b1
   } mv_mode_e;
endpackage

// File: rtl/ixmv_regfile.sv
module ixmv_regfile #(
   parameter int NREG = 32,
   parameter int DW   = 64,
   parameter int AW   = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] ra0,
   output logic [DW-1:0] rd0,
   input  logic [AW-1:0] ra1,
   output logic [DW-1:0] rd1,
   input  logic [AW-1:0] ra2,
   output logic [DW-1:0] rd2
);
   logic [DW-1:0] rows [NREG];

   initial begin
      assert (NREG == (1 << AW)) else $error("regfile depth must be a power of two");
   end

   for (genvar r = 0; r < NREG; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n)
            rows[r] <= '0;
         else if (we && (waddr == AW'(r)))
            rows[r] <= wdata;
      end
   end

   assign rd0 = rows[ra0];
   assign rd1 = rows[ra1];
   assign rd2 = rows[ra2];
endmodule

// File: rtl/ixmv_clamp.sv
module ixmv_clamp #(
   parameter int DW  = 64,
   parameter int VLW = 6
) (
   input  logic [DW-1:0]  idx_val,
   input  logic [VLW-1:0] vl,
   output logic [VLW-1:0] idx_lim
);
   localparam int PAD = DW - VLW;

   initial begin
      assert (DW > VLW) else $error("data width must exceed length width");
   end

   logic [DW-1:0] vl_wide;
   assign vl_wide = {{PAD{1'b0}}, vl};
   assign idx_lim = (idx_val < vl_wide) ? idx_val[VLW-1:0] : vl;
endmodule

// File: rtl/ixmv_seq.sv
module ixmv_seq
   import ixmv_pkg::*;
#(
   parameter int AW  = 5,
   parameter int VLW = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  mv_mode_e       mode,
   input  logic [AW-1:0]  dst_base,
   input  logic [AW-1:0]  idx_base,
   input  logic [VLW-1:0] vlen,
   output logic           busy,
   output logic           done,
   output mv_mode_e       mode_q,
   output logic [AW-1:0]  rt_q,
   output logic [AW-1:0]  ra_q,
   output logic [VLW-1:0] vl_q,
   output logic [VLW-1:0] elem
);
   logic take;
   logic last;

   assign take = start && !busy;
   assign last = (mode_q == MV_SCALAR) || (elem == vl_q - VLW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         mode_q <= MV_SCALAR;
         rt_q   <= '0;
         ra_q   <= '0;
         vl_q   <= '0;
         elem   <= '0;
      end else if (take) begin
         mode_q <= mode;
         rt_q   <= dst_base;
         ra_q   <= idx_base;
         vl_q   <= vlen;
         elem   <= '0;
         if (mode == MV_VECTOR && vlen == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            busy <= 1'b1;
            done <= 1'b0;
         end
      end else if (busy) begin
         if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            elem <= elem + VLW'(1);
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

   a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(rt_q) && $stable(ra_q) && $stable(vl_q)));

   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(busy) || $past(start)));
endmodule

// File: rtl/ixmv_sequencer.sv
module ixmv_sequencer
   import ixmv_pkg::*;
#(
   parameter int NREG = 32,
   parameter int DW   = 64,
   parameter int VLW  = 6,
   parameter int AW   = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           vec_mode,
   input  logic [AW-1:0]  dst_base,
   input  logic [AW-1:0]  idx_base,
   input  logic [VLW-1:0] vlen,
   input  logic           ld_en,
   input  logic [AW-1:0]  ld_addr,
   input  logic [DW-1:0]  ld_data,
   input  logic [AW-1:0]  dbg_addr,
   output logic [DW-1:0]  dbg_data,
   output logic           busy,
   output logic           done,
   output logic           wr_en,
   output logic [AW-1:0]  wr_addr,
   output logic [DW-1:0]  wr_data
);
   mv_mode_e       mode_q;
   logic [AW-1:0]  rt_q, ra_q;
   logic [VLW-1:0] vl_q, elem;
   logic [AW-1:0]  idx_addr, src_addr, dst_addr, foot_off;
   logic [DW-1:0]  idx_val, src_val;
   logic [VLW-1:0] idx_lim;
   logic           rf_we;
   logic [AW-1:0]  rf_waddr;
   logic [DW-1:0]  rf_wdata;

   ixmv_seq #(.AW(AW), .VLW(VLW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mode     (mv_mode_e'(vec_mode)),
      .dst_base (dst_base),
      .idx_base (idx_base),
      .vlen     (vlen),
      .busy     (busy),
      .done     (done),
      .mode_q   (mode_q),
      .rt_q     (rt_q),
      .ra_q     (ra_q),
      .vl_q     (vl_q),
      .elem     (elem)
   );

   assign idx_addr = (mode_q == MV_VECTOR) ? ra_q + AW'(elem) : ra_q;
   assign dst_addr = rt_q + AW'(elem);

   ixmv_clamp #(.DW(DW), .VLW(VLW)) u_clamp (
      .idx_val (idx_val),
      .vl      (vl_q),
      .idx_lim (idx_lim)
   );

   assign src_addr = (mode_q == MV_VECTOR) ? rt_q + AW'(idx_lim) : idx_val[AW-1:0];
   assign foot_off = src_addr - rt_q;

   assign rf_we    = busy || ld_en;
   assign rf_waddr = busy ? dst_addr : ld_addr;
   assign rf_wdata = busy ? src_val  : ld_data;

   ixmv_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .waddr (rf_waddr),
      .wdata (rf_wdata),
      .ra0   (idx_addr),
      .rd0   (idx_val),
      .ra1   (src_addr),
      .rd1   (src_val),
      .ra2   (dbg_addr),
      .rd2   (dbg_data)
   );

   assign wr_en   = busy;
   assign wr_addr = dst_addr;
   assign wr_data = src_val;

   a_r2_footprint: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_q == MV_VECTOR) |-> (VLW'(foot_off) <= vl_q));

   a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && mode_q == MV_VECTOR) |-> (wr_addr == $past(wr_addr) + AW'(1)));

   a_r6_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);
endmodule

// File: tb/ixmv_sequencer_bench.sv
module ixmv_sequencer_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        start = 0, vec_mode = 0, ld_en = 0;
   logic [4:0]  dst_base = 0, idx_base = 0, ld_addr = 0, dbg_addr = 0;
   logic [5:0]  vlen = 0;
   logic [63:0] ld_data = 0;
   logic [63:0] dbg_data, wr_data;
   logic        busy, done, wr_en;
   logic [4:0]  wr_addr;

   logic [63:0] mdl [32];
   int n_tests = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ixmv_sequencer u_ixmv_sequencer (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_mode(vec_mode),
      .dst_base(dst_base), .idx_base(idx_base), .vlen(vlen),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .dbg_addr(dbg_addr), .dbg_data(dbg_data),
      .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load(input int a, input logic [63:0] d);
      ld_en = 1; ld_addr = 5'(a); ld_data = d;
      @(negedge clk);
      ld_en = 0;
      mdl[a] = d;
   endtask

   task automatic verify_all(input string tag);
      for (int a = 0; a < 32; a++) begin
         dbg_addr = 5'(a);
         #1;
         chk(dbg_data == mdl[a], tag, dbg_data, mdl[a]);
      end
   endtask

   task automatic fill(input int p);
      for (int k = 0; k < 32; k++) begin
         logic [63:0] v;
         v = 64'((k * 37 + p * 11) % 13);
         if ((k + p) % 7 == 0) v = 64'hFFFF_FFFF_FFFF_FFF0 | 64'(k);
         if ((k + p) % 11 == 0) v = 64'h8000_0000_0000_0002;
         load(k, v);
      end
   endtask

   task automatic run(input bit vec, input int rt, input int ra, input int vl, input bit inject);
      int n;
      n = vec ? vl : 1;
      vec_mode = vec; dst_base = 5'(rt); idx_base = 5'(ra); vlen = 6'(vl);
      start = 1;
      @(negedge clk);
      start = 0;
      if (n == 0) begin
         chk(done && !busy && !wr_en, "R6 vl0 done without busy/write", {busy, wr_en, done}, 64'b001);
         @(negedge clk);
         chk(!done, "R6 vl0 done single cycle", 64'(done), 0);
         return;
      end
      for (int j = 0; j < n; j++) begin
         logic [63:0] idx, d;
         int c, src, dst;
         idx = mdl[(ra + j) % 32];
         if (vec) begin
            c = (idx < 64'(vl)) ? int'(idx) : vl;
            src = (rt + c) % 32;
         end else
            src = int'(idx[4:0]);
         dst = (rt + j) % 32;
         d = mdl[src];
         chk(busy && !done, "R5 busy during run", {busy, done}, 64'b10);
         chk(wr_en && wr_addr == 5'(dst), vec ? "R2/R10 write address" : "R1/R10 write address",
             64'(wr_addr), 64'(dst));
         chk(wr_data == d, vec ? "R2/R3/R4 write data" : "R1 write data", wr_data, d);
         if (inject && j == 0) begin
            start = 1; vec_mode = 0; dst_base = 5'(rt + 3); idx_base = 5'(ra + 1); vlen = 6'(1);
            ld_en = 1; ld_addr = 5'((rt + n) % 32); ld_data = 64'hDEAD_BEEF_0000_0001;
         end
         @(negedge clk);
         start = 0; ld_en = 0;
         mdl[dst] = d;
      end
      chk(done && !busy, "R5 done after final write", {busy, done}, 64'b01);
      @(negedge clk);
      chk(!done, "R5 done single cycle", 64'(done), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int k = 0; k < 32; k++) mdl[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk(!busy && !done && !wr_en, "R11 reset outputs", {busy, done, wr_en}, 0);
      verify_all("R11/R9 reset registers zero");

      // R8 loads and R9 debug reads
      fill(0);
      verify_all("R8/R9 idle load");

      // R2 R3 vector sweep
      for (int vl = 0; vl <= 9; vl++) begin
         for (int t = 0; t < 3; t++) begin
            int rt, ra;
            rt = (t == 0) ? 0 : (t == 1) ? 7 : 29;
            ra = (rt + 13 + vl) % 32;
            fill(vl * 3 + t);
            run(1, rt, ra, vl, 0);
            verify_all("R2 vector sweep registers");
         end
      end

      // R3 huge indices clamp to VL
      fill(1);
      load(20, 64'hFFFF_FFFF_FFFF_FFFF);
      load(21, 64'h8000_0000_0000_0000);
      load(22, 64'h0000_0001_0000_0001);
      run(1, 2, 20, 3, 0);
      verify_all("R3 large index clamp");

      // R4 dependency between elements
      fill(2);
      load(20, 3); load(21, 0); load(22, 0); load(23, 0);
      run(1, 4, 20, 4, 0);
      verify_all("R4 later element sees earlier write");

      // R1 scalar moves, including wrap of the index value
      for (int s = 0; s < 4; s++) begin
         fill(5 + s);
         load(10 + s, 64'(s * 9 + 37));
         run(0, 3 + s * 5, 10 + s, 0, 0);
         verify_all("R1 scalar move");
      end

      // R7 start and R8 load dropped while busy
      for (int s = 0; s < 3; s++) begin
         fill(11 + s);
         run(1, 8 + s, 1 + s, 4 + s, 1);
         verify_all("R7/R8 injected start and load dropped");
      end

      // R2 wrap of destination past register 31
      fill(4);
      run(1, 30, 5, 5, 0);
      verify_all("R2 destination wrap");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule